// File: doc/BRIEF.md
# Three-Axis Motion Interrupt Generator

This block watches a stream of three-axis acceleration samples, each a signed 8-bit value per axis that arrives with a one-cycle sample tick. On every tick it compares each axis against a programmable 7-bit threshold and derives a high flag and a low flag per axis. A configuration byte picks which of the six flags take part and how they combine: any one of them (wake-up style), all of them (free-fall style), a single recognised direction held (orientation position), or a change to a new recognised direction (orientation movement).

A qualifying event must hold for a programmable number of consecutive samples before it counts. The interrupt line either follows the qualified event sample by sample or, when latching is selected, stays raised until the host reads the source word. The source word reports the six flags of the latest sample together with the interrupt state. Typical settings are 0x95, which flags free fall when all three axes sit near zero, and 0x0A, which flags wake-up when X or Y exceeds the threshold.

Top module: `motion_irq_gen`

## Requirements
- R1: The configuration byte carries the mode in bits 7:6 and the flag enables in bits 5:0, one per flag in the order bit5 Z-high, bit4 Z-low, bit3 Y-high, bit2 Y-low, bit1 X-high, bit0 X-low; the same order places the flags in the source word.
- R2: In modes 00 and 10 an axis high flag is set when the sample magnitude is strictly above the threshold and its low flag when strictly below; at equality neither is set, and -128 has magnitude 128.
- R3: In modes 01 and 11 an axis high flag is set when the signed sample is above +threshold and its low flag when it is below -threshold.
- R4: Mode 00 raises the event when at least one enabled flag is set.
- R5: Mode 10 raises the event when every enabled flag is set; with no flag enabled it never raises.
- R6: Mode 11 raises the event on every sample in which exactly one enabled flag is set.
- R7: Mode 01 raises the event for one sample when exactly one enabled flag is set and that flag differs from the last such single-flag direction seen since reset.
- R8: With duration value N, the event is reported only on a sample whose condition is true and whose preceding N samples also had a true condition; N = 0 reports at once, and a false sample restarts the count.
- R9: With latching off, the interrupt output equals the qualified event of the latest sample and changes only in the cycle after a sample tick.
- R10: With latching on, a qualified event sets the interrupt, which then holds until the cycle after a read strobe; an event in the same cycle as the read wins.
- R11: The source word reads bit 7 as 0, bit 6 as the interrupt output, and bits 5:0 as the flags of the latest sample.
- R12: After reset the interrupt output is 0 and the source word is 0x00.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| smp_tick | input | 1 | One-cycle strobe marking a new sample on the axis inputs |
| smp_x | input | 8 | X sample, two's complement |
| smp_y | input | 8 | Y sample, two's complement |
| smp_z | input | 8 | Z sample, two's complement |
| cfg_mode | input | 8 | Mode bits 7:6 and flag enables 5:0 |
| thresh | input | 7 | Unsigned threshold |
| dur | input | 7 | Minimum consecutive samples before the event counts |
| latch_en | input | 1 | 1 selects latched interrupt, 0 level-following |
| src_rd | input | 1 | Source-word read strobe, clears the latch |
| irq | output | 1 | Interrupt output |
| src_data | output | 8 | Source word: 0, interrupt, six flags |

## Verification
The combining logic is tried with samples placed on both sides of the threshold and exactly on it, so that strict comparison and the -128 magnitude are separated from off-by-one variants. Each mode sees one pattern that should fire and one that should not: a single axis out of range against all axes quiet for OR and AND, an empty enable set for AND, and one against two recognised directions for orientation position. The movement mode is driven through a repeated direction, an unrecognised sample and a return to the old direction, which distinguishes a change detector from a level detector. Duration, level-following and latch-with-read behaviour are probed with runs broken by a single quiet sample and with a read that coincides with a new event.

// File: rtl/motion_irq_gen.sv
`timescale 1ns/1ps
module motion_irq_gen #(
  parameter int SW = 8,
  parameter int TW = 7,
  parameter int DW = 7
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          smp_tick,
  input  logic [SW-1:0] smp_x,
  input  logic [SW-1:0] smp_y,
  input  logic [SW-1:0] smp_z,
  input  logic [7:0]    cfg_mode,
  input  logic [TW-1:0] thresh,
  input  logic [DW-1:0] dur,
  input  logic          latch_en,
  input  logic          src_rd,
  output logic          irq,
  output logic [7:0]    src_data
);
  localparam int NAX = 3;
  localparam int NFL = 2 * NAX;

  logic [NAX-1:0][SW-1:0] smp_all;
  logic [NFL-1:0] flags_n, flag_q, hit, dir_q, en;
  logic [1:0]     mode;
  logic           known, cond, fire, act_q, lat_q;
  logic [DW-1:0]  cnt;

  assign smp_all = {smp_z, smp_y, smp_x};
  assign mode    = cfg_mode[7:6];
  assign en      = cfg_mode[NFL-1:0];

  for (genvar i = 0; i < NAX; i++) begin : g_axis
    logic [SW-1:0] mag;
    logic          neg, above, below;
    assign neg   = smp_all[i][SW-1];
    assign mag   = neg ? (~smp_all[i] + 1'b1) : smp_all[i];
    assign above = mag > SW'(thresh);
    assign below = mag < SW'(thresh);
    assign flags_n[2*i+1] = mode[0] ? (above && !neg) : above;
    assign flags_n[2*i]   = mode[0] ? (above && neg)  : below;
  end

  assign hit   = flags_n & en;
  assign known = (hit != '0) && ((hit & (hit - 1'b1)) == '0);

  always_comb begin
    case (mode)
      2'b00:   cond = |hit;
      2'b10:   cond = (en != '0) && ((~flags_n & en) == '0);
      2'b11:   cond = known;
      default: cond = known && (hit != dir_q);
    endcase
  end

  assign fire = cond && (cnt >= dur);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= '0;
      dir_q  <= '0;
      act_q  <= 1'b0;
      cnt    <= '0;
    end else if (smp_tick) begin
      flag_q <= flags_n;
      act_q  <= fire;
      if (known) dir_q <= hit;
      if (!cond)          cnt <= '0;
      else if (cnt < dur) cnt <= cnt + 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                lat_q <= 1'b0;
    else if (smp_tick && fire) lat_q <= 1'b1;
    else if (src_rd)           lat_q <= 1'b0;
  end

  assign irq      = latch_en ? lat_q : act_q;
  assign src_data = {1'b0, irq, flag_q};

  AST_IRQ_ONLY_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    (!smp_tick && !src_rd && $stable(latch_en)) |=> $stable(irq)); // R9
  AST_LATCH_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (latch_en && irq && !src_rd) |=> (irq || !latch_en)); // R10
  AST_READ_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (src_rd && !smp_tick) |=> !lat_q); // R10
  AST_NO_COND_NO_EVENT: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && !cond) |=> !act_q); // R8
  AST_ZERO_DUR_IMMEDIATE: assert property (@(posedge clk) disable iff (!rst_n)
    (smp_tick && cond && dur == '0) |=> act_q); // R8
  AST_HI_LO_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    !(flag_q[5] && flag_q[4]) && !(flag_q[3] && flag_q[2]) && !(flag_q[1] && flag_q[0])); // R2
endmodule

// File: tb/motion_irq_gen_test.sv
`timescale 1ns/1ps
module motion_irq_gen_test;
  logic clk = 1'b0, rst_n = 1'b0, smp_tick = 1'b0, latch_en = 1'b0, src_rd = 1'b0;
  logic [7:0] smp_x = '0, smp_y = '0, smp_z = '0, cfg_mode = '0;
  logic [6:0] thresh = 7'd16, dur = '0;
  logic irq;
  logic [7:0] src_data;
  int checks = 0, errs = 0;

  always #4 clk = ~clk;

  motion_irq_gen uut (.clk(clk), .rst_n(rst_n), .smp_tick(smp_tick), .smp_x(smp_x),
    .smp_y(smp_y), .smp_z(smp_z), .cfg_mode(cfg_mode), .thresh(thresh), .dur(dur),
    .latch_en(latch_en), .src_rd(src_rd), .irq(irq), .src_data(src_data));

  // {cfg, thr, x, y, z, flags ZH ZL YH YL XH XL, irq}; dur 0, latch off
  localparam int NV = 11;
  localparam logic [45:0] VEC [NV] = '{
    {8'h0A, 7'd16,  8'd20,  8'd0,   8'd64, 6'b100110, 1'b1},  // R1 R4 wake-up fires
    {8'h0A, 7'd16,  8'd16,  8'hF0,  8'd0,  6'b010000, 1'b0},  // R2 equality sets neither
    {8'h0A, 7'd16,  8'd0,   8'h80,  8'd0,  6'b011001, 1'b1},  // R2 -128 is above
    {8'h95, 7'd16,  8'd3,   8'hFB,  8'd2,  6'b010101, 1'b1},  // R5 free fall
    {8'h95, 7'd16,  8'd3,   8'hD8,  8'd2,  6'b011001, 1'b0},  // R5 one axis out
    {8'h80, 7'd16,  8'd0,   8'd0,   8'd0,  6'b010101, 1'b0},  // R5 nothing enabled
    {8'hFF, 7'd16,  8'd0,   8'd0,   8'd64, 6'b100000, 1'b1},  // R3 R6 one direction
    {8'hFF, 7'd16,  8'hD8,  8'd0,   8'd64, 6'b100001, 1'b0},  // R6 two directions
    {8'hFF, 7'd16,  8'hD8,  8'hFB,  8'd3,  6'b000001, 1'b1},  // R3 negative side
    {8'h0A, 7'd127, 8'h80,  8'd127, 8'd0,  6'b010010, 1'b1},  // R2 full-scale threshold
    {8'h15, 7'd0,   8'd0,   8'd0,   8'd0,  6'b000000, 1'b0}   // R2 zero threshold
  };

  task automatic chk(input logic [7:0] act, input logic [7:0] exp, input string req);
    checks++;
    if (act !== exp) begin
      errs++;
      $display("FAIL %s: got %h expected %h at %0t", req, act, exp, $time);
    end
  endtask

  task automatic sample(input logic [7:0] x, input logic [7:0] y, input logic [7:0] z);
    @(negedge clk);
    smp_x = x; smp_y = y; smp_z = z; smp_tick = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0;
  endtask

  task automatic do_reset();
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
  endtask

  initial begin
    #1_000_000;
    errs++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk({7'd0, irq}, 8'd0, "R12");
    chk(src_data, 8'h00, "R12");
    rst_n = 1'b1;

    for (int i = 0; i < NV; i++) begin
      cfg_mode = VEC[i][45:38];
      thresh   = VEC[i][37:31];
      sample(VEC[i][30:23], VEC[i][22:15], VEC[i][14:7]);
      chk({7'd0, irq}, {7'd0, VEC[i][0]}, "R9");
      chk(src_data, {1'b0, VEC[i][0], VEC[i][6:1]}, "R11");
    end

    // R7 orientation movement
    do_reset();
    cfg_mode = 8'h7F; thresh = 7'd16; dur = '0;
    sample(8'd0, 8'd0, 8'd64);  chk({7'd0, irq}, 8'd1, "R7");
    sample(8'd0, 8'd0, 8'd64);  chk({7'd0, irq}, 8'd0, "R7");
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd1, "R7");
    sample(8'd0, 8'd0, 8'd0);   chk({7'd0, irq}, 8'd0, "R7");
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd0, "R7");

    // R8 duration
    do_reset();
    cfg_mode = 8'h0A; dur = 7'd2;
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd0, "R8");
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd0, "R8");
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd1, "R8");
    // R9 level holds between ticks
    repeat (3) @(negedge clk);
    chk({7'd0, irq}, 8'd1, "R9");
    sample(8'd0, 8'd0, 8'd0);   chk({7'd0, irq}, 8'd0, "R8");
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd0, "R8");

    // R10 latch
    do_reset();
    latch_en = 1'b1; dur = '0;
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd1, "R10");
    sample(8'd0, 8'd0, 8'd0);   chk({7'd0, irq}, 8'd1, "R10");
    chk(src_data, 8'h55, "R11");
    @(negedge clk); src_rd = 1'b1;
    @(negedge clk); src_rd = 1'b0;
    chk({7'd0, irq}, 8'd0, "R10");
    sample(8'd0, 8'd0, 8'd0);   chk({7'd0, irq}, 8'd0, "R10");
    sample(8'd40, 8'd0, 8'd0);  chk({7'd0, irq}, 8'd1, "R10");
    @(negedge clk);
    smp_x = 8'd40; smp_tick = 1'b1; src_rd = 1'b1;
    @(negedge clk);
    smp_tick = 1'b0; src_rd = 1'b0;
    chk({7'd0, irq}, 8'd1, "R10");

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, errs);
    $finish;
  end
endmodule